// File: doc/BRIEF.md
# Path Status Byte Builder with Forced Remote Defect Codes

This block assembles the path status byte that the transmitter places in each outgoing frame. Each frame, the transmit path's ordinary logic supplies a normally generated status byte. A controller can take ownership of any subset of the byte's bits by writing a value together with a bit mask. Two separately written force controls can then impose a fixed two-bit remote defect code on bits 5 and 6 of the byte, overriding both the normal value and any value the controller supplied for those two bits.

The merged byte is registered once per frame on the strobe that marks the status byte slot, so a control change made in the middle of a frame never yields a byte that is half old and half new. Bits are numbered 1 (most significant) to 8 (least significant), so bits 5 and 6 are vector indices 3 and 2 of the byte. Remote error counting and the defect detection that produces the normal indication live elsewhere.

Top module: `pstat_byte_builder`

## Requirements
- R1: While `rst_n` is low, `g1_out` is 8'h00, `g1_upd` is 0, both force controls are cleared and the controller mask is all zero.
- R2: `g1_out` changes only on a clock edge where `frame_slot` is high; on every other edge it holds its value.
- R3: With no force set and a zero controller mask, a slot edge loads `norm_byte` unchanged into `g1_out`.
- R4: A `ctl_wr` edge stores `ctl_mask` and `ctl_byte`; from then on every slot edge takes each bit whose mask bit is 1 from the stored value and each other bit from `norm_byte`, until the next `ctl_wr` replaces both (a zero mask hands every bit back).
- R5: With force-01 set, a slot edge yields index 3 (bit 5) = 0 and index 2 (bit 6) = 1, i.e. `g1_out[3:2]` = 2'b01.
- R6: With only force-10 set, a slot edge yields index 3 (bit 5) = 1 and index 2 (bit 6) = 0, i.e. `g1_out[3:2]` = 2'b10.
- R7: With both forces set, force-01 wins and `g1_out[3:2]` = 2'b01.
- R8: A set force overrides controller-owned values on indices 3 and 2.
- R9: Forces never alter indices 7:4 and 1:0; those bits keep the controller or normal value.
- R10: `g1_upd` is high for exactly the cycle following each slot edge and low otherwise.
- R11: A `ctl_wr` or `frc_wr` on the same edge as a slot is not used for that slot; it first applies at the next slot.
- R12: After a reset, force controls set before it no longer affect the byte until written again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Transmit byte clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| frame_slot | input | 1 | One-cycle strobe marking the status byte slot of a frame |
| norm_byte | input | 8 | Normally processed status byte |
| ctl_wr | input | 1 | Controller write strobe for value and mask |
| ctl_byte | input | 8 | Controller-supplied byte value |
| ctl_mask | input | 8 | Bits of the byte the controller takes over (1 = controller) |
| frc_wr | input | 1 | Write strobe for both force controls |
| frc01_wd | input | 1 | New force-01 setting (bit 5 = 0, bit 6 = 1) |
| frc10_wd | input | 1 | New force-10 setting (bit 5 = 1, bit 6 = 0) |
| g1_out | output | 8 | Status byte for insertion into the frame |
| g1_upd | output | 1 | High in the cycle after `g1_out` was loaded |

## Verification
The hardest situation to reach is the stack of all three sources at once: controller ownership of bits 5 and 6, both force controls set, and a control write landing on the very edge of a slot. Random stimulus writes masks and forces often enough that these overlap many times, and directed steps place a write and a slot on the same edge, set both forces over a controller-owned field, and reset while forces are set, each compared with a bench model of the priority order.

// File: rtl/pstat_pkg.sv
package pstat_pkg;

    localparam int unsigned BYTE_W   = 8;
    // bits 5 and 6 of the byte (MSB numbered 1) sit at indices 3 and 2
    localparam int unsigned CODE_LSB = 2;
    localparam int unsigned CODE_W   = 2;

    localparam logic [CODE_W-1:0] CODE_F01 = 2'b01;
    localparam logic [CODE_W-1:0] CODE_F10 = 2'b10;

    typedef struct packed {
        logic [BYTE_W-1:0] val;
        logic [BYTE_W-1:0] msk;
        logic              f01;
        logic              f10;
    } ctl_state_t;

    typedef struct packed {
        logic [BYTE_W-1:0] byte_v;
        logic              upd;
    } out_state_t;

endpackage

// File: rtl/pstat_ctl_regs.sv
module pstat_ctl_regs
    import pstat_pkg::*;
#(
    parameter int unsigned W = BYTE_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         ctl_wr,
    input  logic [W-1:0] ctl_byte,
    input  logic [W-1:0] ctl_mask,
    input  logic         frc_wr,
    input  logic         frc01_wd,
    input  logic         frc10_wd,
    output logic [W-1:0] ovr_val,
    output logic [W-1:0] ovr_msk,
    output logic         frc01,
    output logic         frc10
);

    ctl_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (ctl_wr) begin
            st_d.msk = ctl_mask;
            st_d.val = ctl_byte & ctl_mask;
        end
        if (frc_wr) begin
            st_d.f01 = frc01_wd;
            st_d.f10 = frc10_wd;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign ovr_val = st_q.val;
    assign ovr_msk = st_q.msk;
    assign frc01   = st_q.f01;
    assign frc10   = st_q.f10;

endmodule

// File: rtl/pstat_merge.sv
module pstat_merge
    import pstat_pkg::*;
#(
    parameter int unsigned W    = BYTE_W,
    parameter int unsigned CLSB = CODE_LSB,
    parameter int unsigned CW   = CODE_W
) (
    input  logic [W-1:0] norm_byte,
    input  logic [W-1:0] ovr_val,
    input  logic [W-1:0] ovr_msk,
    input  logic         frc01,
    input  logic         frc10,
    output logic [W-1:0] merged
);

    localparam int unsigned CMSB = CLSB + CW - 1;

    logic [W-1:0]  base;
    logic [CW-1:0] code;
    logic          frc_any;

    // per-bit choice between controller and normal source
    for (genvar i = 0; i < W; i++) begin : g_bit
        assign base[i] = ovr_msk[i] ? ovr_val[i] : norm_byte[i];
    end

    always_comb begin
        frc_any = frc01 | frc10;
        if (frc01) begin
            code = CODE_F01;
        end else if (frc10) begin
            code = CODE_F10;
        end else begin
            code = base[CMSB:CLSB];
        end
    end

    for (genvar i = 0; i < W; i++) begin : g_out
        if (i >= CLSB && i <= CMSB) begin : g_code
            assign merged[i] = frc_any ? code[i-CLSB] : base[i];
        end else begin : g_pass
            assign merged[i] = base[i];
        end
    end

endmodule

// File: rtl/pstat_byte_builder.sv
module pstat_byte_builder
    import pstat_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        frame_slot,
    input  logic [7:0]  norm_byte,
    input  logic        ctl_wr,
    input  logic [7:0]  ctl_byte,
    input  logic [7:0]  ctl_mask,
    input  logic        frc_wr,
    input  logic        frc01_wd,
    input  logic        frc10_wd,
    output logic [7:0]  g1_out,
    output logic        g1_upd
);

    logic [BYTE_W-1:0] ovr_val;
    logic [BYTE_W-1:0] ovr_msk;
    logic              frc01;
    logic              frc10;
    logic [BYTE_W-1:0] merged;

    pstat_ctl_regs #(.W(BYTE_W)) i_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .ctl_wr   (ctl_wr),
        .ctl_byte (ctl_byte),
        .ctl_mask (ctl_mask),
        .frc_wr   (frc_wr),
        .frc01_wd (frc01_wd),
        .frc10_wd (frc10_wd),
        .ovr_val  (ovr_val),
        .ovr_msk  (ovr_msk),
        .frc01    (frc01),
        .frc10    (frc10)
    );

    pstat_merge #(.W(BYTE_W), .CLSB(CODE_LSB), .CW(CODE_W)) i_merge (
        .norm_byte (norm_byte),
        .ovr_val   (ovr_val),
        .ovr_msk   (ovr_msk),
        .frc01     (frc01),
        .frc10     (frc10),
        .merged    (merged)
    );

    out_state_t out_d, out_q;

    always_comb begin
        out_d     = out_q;
        out_d.upd = 1'b0;
        if (frame_slot) begin
            out_d.byte_v = merged;
            out_d.upd    = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_q <= '0;
        end else begin
            out_q <= out_d;
        end
    end

    assign g1_out = out_q.byte_v;
    assign g1_upd = out_q.upd;

endmodule

// File: rtl/pstat_byte_builder_chk.sv
module pstat_byte_builder_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       slot,
    input logic       f01,
    input logic       f10,
    input logic [7:0] out_byte,
    input logic       upd
);

    logic seen_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seen_q <= 1'b0;
        end else begin
            seen_q <= 1'b1;
        end
    end

    p_reset_clear_r1: assert property (@(posedge clk)
        !rst_n |=> (out_byte == 8'h00 && !upd));

    p_hold_between_r2: assert property (@(posedge clk) disable iff (!rst_n || !seen_q)
        !$past(slot) |-> $stable(out_byte));

    p_code01_r5: assert property (@(posedge clk) disable iff (!rst_n || !seen_q)
        ($past(slot) && $past(f01)) |-> (out_byte[3:2] == 2'b01));

    p_code10_r6: assert property (@(posedge clk) disable iff (!rst_n || !seen_q)
        ($past(slot) && !$past(f01) && $past(f10)) |-> (out_byte[3:2] == 2'b10));

    p_both_win01_r7: assert property (@(posedge clk) disable iff (!rst_n || !seen_q)
        ($past(slot) && $past(f01) && $past(f10)) |-> (out_byte[3:2] == 2'b01));

    p_upd_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n || !seen_q)
        upd == $past(slot));

endmodule

bind pstat_byte_builder pstat_byte_builder_chk i_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .slot     (frame_slot),
    .f01      (frc01),
    .f10      (frc10),
    .out_byte (g1_out),
    .upd      (g1_upd)
);

// File: tb/test_pstat_byte_builder.sv
`timescale 1ns/1ps
module test_pstat_byte_builder;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       frame_slot;
    logic [7:0] norm_byte;
    logic       ctl_wr;
    logic [7:0] ctl_byte;
    logic [7:0] ctl_mask;
    logic       frc_wr;
    logic       frc01_wd;
    logic       frc10_wd;
    logic [7:0] g1_out;
    logic       g1_upd;

    always #2 clk = ~clk;

    pstat_byte_builder i_pstat_byte_builder (
        .clk(clk), .rst_n(rst_n), .frame_slot(frame_slot), .norm_byte(norm_byte),
        .ctl_wr(ctl_wr), .ctl_byte(ctl_byte), .ctl_mask(ctl_mask),
        .frc_wr(frc_wr), .frc01_wd(frc01_wd), .frc10_wd(frc10_wd),
        .g1_out(g1_out), .g1_upd(g1_upd)
    );

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 0;

    logic [7:0] m_val, m_msk, m_out;
    logic       m_f01, m_f10, m_upd;

    function automatic logic [7:0] model_merge(logic [7:0] nb, logic [7:0] v,
                                               logic [7:0] mk, logic a, logic b);
        logic [7:0] r;
        r = (mk & v) | (~mk & nb);
        if (a)      r[3:2] = 2'b01;
        else if (b) r[3:2] = 2'b10;
        return r;
    endfunction

    task automatic chk(string tag, logic [7:0] got, logic [7:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %02h expected %02h", tag, got, exp);
        end
    endtask

    task automatic model_reset();
        m_val = '0; m_msk = '0; m_f01 = 0; m_f10 = 0; m_out = '0; m_upd = 0;
    endtask

    // drive one cycle, advance model with pre-edge state, check after the edge
    task automatic cyc(logic s, logic [7:0] nb, logic cw, logic [7:0] cb, logic [7:0] cm,
                       logic fw, logic a, logic b, string tag);
        @(negedge clk);
        frame_slot = s; norm_byte = nb; ctl_wr = cw; ctl_byte = cb; ctl_mask = cm;
        frc_wr = fw; frc01_wd = a; frc10_wd = b;
        if (s) m_out = model_merge(nb, m_val, m_msk, m_f01, m_f10);
        m_upd = s;
        if (cw) begin m_msk = cm; m_val = cb & cm; end
        if (fw) begin m_f01 = a; m_f10 = b; end
        @(posedge clk);
        @(negedge clk);
        chk(tag, g1_out, m_out);
        chk("R10", {7'd0, g1_upd}, {7'd0, m_upd});
        frame_slot = 0; ctl_wr = 0; frc_wr = 0;
    endtask

    initial begin
        #(4 * 200000);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: got hung expected finish");
            $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd7341));
        rst_n = 0; frame_slot = 0; norm_byte = 0; ctl_wr = 0; ctl_byte = 0;
        ctl_mask = 0; frc_wr = 0; frc01_wd = 0; frc10_wd = 0;
        model_reset();
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R1", g1_out, 8'h00);
        chk("R1", {7'd0, g1_upd}, 8'h00);
        rst_n = 1;

        // R3 plain pass-through
        cyc(1, 8'h3C, 0, 0, 0, 0, 0, 0, "R3");
        cyc(0, 8'hFF, 0, 0, 0, 0, 0, 0, "R2");
        // R4 controller takes upper nibble, persists
        cyc(0, 8'h00, 1, 8'hA5, 8'hF0, 0, 0, 0, "R2");
        cyc(1, 8'h0F, 0, 0, 0, 0, 0, 0, "R4");
        cyc(1, 8'h03, 0, 0, 0, 0, 0, 0, "R4");
        // R11 write on slot edge applies next slot
        cyc(1, 8'h11, 1, 8'h00, 8'h00, 1, 1, 0, "R11");
        cyc(1, 8'h11, 0, 0, 0, 0, 0, 0, "R5");
        // R8/R9 controller owns 0x0C and outer bits, force10 wins field
        cyc(0, 8'h00, 1, 8'hFF, 8'hCF, 1, 0, 1, "R2");
        cyc(1, 8'h00, 0, 0, 0, 0, 0, 0, "R8");
        chk("R9", g1_out & 8'hF3, 8'hC3);
        chk("R6", {6'd0, g1_out[3:2]}, 8'h02);
        // R7 both set
        cyc(0, 8'h00, 0, 0, 0, 1, 1, 1, "R2");
        cyc(1, 8'h5A, 0, 0, 0, 0, 0, 0, "R7");
        chk("R7", {6'd0, g1_out[3:2]}, 8'h01);
        // R12 reset clears forces
        @(negedge clk); rst_n = 0; model_reset();
        @(negedge clk);
        chk("R1", g1_out, 8'h00);
        rst_n = 1;
        cyc(1, 8'h5A, 0, 0, 0, 0, 0, 0, "R12");
        chk("R12", g1_out, 8'h5A);

        for (int k = 0; k < 3000; k++) begin
            logic s, cw, fw, a, b;
            logic [7:0] nb, cb, cm;
            string tag;
            s  = ($urandom % 4) == 0;
            cw = ($urandom % 8) == 0;
            fw = ($urandom % 8) == 0;
            a  = $urandom % 2; b = $urandom % 2;
            nb = $urandom; cb = $urandom; cm = $urandom;
            if (!s)                 tag = "R2";
            else if (m_f01 && m_f10) tag = "R7";
            else if (m_f01)         tag = "R5";
            else if (m_f10)         tag = "R6";
            else if (m_msk != 0)    tag = "R4";
            else                    tag = "R3";
            cyc(s, nb, cw, cb, cm, fw, a, b, tag);
        end

        done = 1;
        $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end

endmodule